// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Model

This block is a synthesizable stand-in for the digital serial port of a multichannel delta-sigma converter. The analog core is not modelled. A conversion is a fixed count of system clocks. When that count runs out, the result is taken from a test input and held in a static shift register. The block then goes to sleep by itself, whether or not the chip-select is asserted.

A host reads the result through a four-wire port driven by the host's own serial clock. Chip-select is active low. The host can pull chip-select low at any time to poll the end-of-conversion flag on the data output. The first rising serial-clock edge with chip-select low ends sleep and starts a 32-bit frame. On the same rising edges, the host shifts in a channel word. The host may cut a frame short by raising chip-select; this starts a new conversion at once. A channel word that was not complete when chip-select rose is dropped.

The serial clock, chip-select and data input are synchronized to the system clock, and edges are found on the synchronized copies. Only the mode in which the host supplies the serial clock is modelled. A flag reports a chip-select falling edge that found the serial clock high.

Top module: `adc_serial_port`

## Requirements
- R1: At each chip-select falling edge, `mode_err` takes the synchronized serial-clock level (1 = high, clock mode not selected). While `mode_err` is 1, serial-clock edges do not end sleep and the output keeps showing the sleep flag 0.
- R2: `sdo_en` is 0 whenever the synchronized chip-select is high and 1 whenever it is low.
- R3: While a conversion runs, `sdo` is 1 (end-of-conversion flag set), and a chip-select low read shows that 1.
- R4: A conversion lasts CONV_CYCLES system clocks. At its end the block enters sleep, independent of chip-select, captures `result_sign` and `result_in`, and `sdo` shows 0.
- R5: The frame is 32 bits, sent most significant first: bit 31 is the end-of-conversion flag (0), bit 30 is 0, bit 29 is the sign, bits 28 down to 29-RES_W are the result from its MSB, and the remaining low bits are 0.
- R6: Frame bit 31 is on `sdo` before the first rising edge. Each serial-clock falling edge moves to the next bit, so bit 31-k is valid at rising edge k+1.
- R7: The 32nd falling edge starts a new conversion, and `sdo` returns to 1.
- R8: A chip-select rising edge after the first rising edge and before the 32nd falling edge aborts the frame and starts a new conversion.
- R9: The channel word is taken only at its 6th rising edge. A frame aborted before that edge leaves the channel outputs unchanged.
- R10: The channel word is 6 bits, MSB first on `sdi`: enable, single-ended select, odd/sign, then a 3-bit address. The channel outputs take the last five bits only when the enable bit is 1.
- R11: After reset a conversion is in progress, `mode_err` is 0, and the channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data input (channel word) |
| result_sign | input | 1 | Sign of the test result |
| result_in | input | RES_W | Test result magnitude, captured at the end of a conversion |
| sdo | output | 1 | Serial data output value |
| sdo_en | output | 1 | Output enable for `sdo` (0 = high impedance) |
| mode_err | output | 1 | Serial clock was high at the last chip-select fall |
| chan_sgl | output | 1 | Latched single-ended select |
| chan_odd | output | 1 | Latched odd/sign select |
| chan_addr | output | ADDR_W | Latched channel address |

## Verification
The bench aborts frames after a random number of rising edges, both before and after the 6th. A design that commits a partial word would change the channel outputs, and one that misses the abort would keep showing sleep rather than the busy flag. It also runs a channel word whose enable bit is 0, and it lets a conversion finish while chip-select stays low; a design that waits for chip-select would never show the sleep flag. A chip-select fall with the serial clock high must raise the mode flag and leave the block asleep. The stored frame must still come out intact on the next proper transfer, so an off-by-one shift or a lost result shows up as a wrong bit.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W       = 24,
  parameter int ADDR_W      = 3,
  parameter int CONV_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              result_sign,
  input  logic [RES_W-1:0]  result_in,
  output logic              sdo,
  output logic              sdo_en,
  output logic              mode_err,
  output logic              chan_sgl,
  output logic              chan_odd,
  output logic [ADDR_W-1:0] chan_addr
);
  localparam int FRAME_W = 32;
  localparam int PAD_W   = FRAME_W - 3 - RES_W;
  localparam int WORD_W  = ADDR_W + 3;
  localparam int CNT_W   = $clog2(CONV_CYCLES + 1);
  localparam int RC_W    = $clog2(WORD_W + 1);
  localparam int FC_W    = $clog2(FRAME_W);

  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_DATA} state_t;

  state_t state;
  logic [1:0] cs_sync, sck_sync, sdi_sync;
  logic cs_d, sck_d;
  logic [CNT_W-1:0] conv_cnt;
  logic [FRAME_W-1:0] frame_sh;
  logic [RC_W-1:0] rise_cnt;
  logic [FC_W-1:0] fall_cnt;
  logic [WORD_W-2:0] word_sh;

  wire cs_s     = cs_sync[1];
  wire sck_s    = sck_sync[1];
  wire sdi_s    = sdi_sync[1];
  wire cs_fall  = cs_d & ~cs_s;
  wire cs_rise  = ~cs_d & cs_s;
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire conv_done = (state == ST_CONV) && (conv_cnt == CNT_W'(CONV_CYCLES - 1));
  wire wake      = (state == ST_SLEEP) && !cs_s && sck_rise && !mode_err;
  wire word_last = (state == ST_DATA) && sck_rise && (rise_cnt == RC_W'(WORD_W - 1));
  wire last_fall = (state == ST_DATA) && sck_fall && (fall_cnt == FC_W'(FRAME_W - 1));
  wire abort     = (state == ST_DATA) && cs_rise;
  wire [WORD_W-1:0] word_full = {word_sh, sdi_s};

  assign sdo_en = ~cs_s;
  assign sdo    = (state == ST_CONV) ? 1'b1 : frame_sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= 2'b11;
      sck_sync <= 2'b00;
      sdi_sync <= 2'b00;
      cs_d     <= 1'b1;
      sck_d    <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[0], cs_n};
      sck_sync <= {sck_sync[0], sck};
      sdi_sync <= {sdi_sync[0], sdi};
      cs_d     <= cs_s;
      sck_d    <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_err <= 1'b0;
    else if (cs_fall) mode_err <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CONV;
      conv_cnt <= '0;
      frame_sh <= '0;
      rise_cnt <= '0;
      fall_cnt <= '0;
      word_sh  <= '0;
    end else begin
      case (state)
        ST_CONV: begin
          if (conv_done) begin
            state    <= ST_SLEEP;
            conv_cnt <= '0;
            frame_sh <= {2'b00, result_sign, result_in, {PAD_W{1'b0}}};
          end else begin
            conv_cnt <= conv_cnt + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            state    <= ST_DATA;
            rise_cnt <= RC_W'(1);
            fall_cnt <= '0;
            word_sh  <= {{(WORD_W-2){1'b0}}, sdi_s};
          end
        end
        default: begin
          if (abort || last_fall) begin
            state    <= ST_CONV;
            conv_cnt <= '0;
          end else begin
            if (sck_rise && rise_cnt < RC_W'(WORD_W)) begin
              rise_cnt <= rise_cnt + 1'b1;
              word_sh  <= word_full[WORD_W-2:0];
            end
            if (sck_fall) begin
              fall_cnt <= fall_cnt + 1'b1;
              frame_sh <= {frame_sh[FRAME_W-2:0], 1'b0};
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_sgl  <= 1'b0;
      chan_odd  <= 1'b0;
      chan_addr <= '0;
    end else if (word_last && !abort && word_full[WORD_W-1]) begin
      chan_sgl  <= word_full[WORD_W-2];
      chan_odd  <= word_full[WORD_W-3];
      chan_addr <= word_full[ADDR_W-1:0];
    end
  end

  a_r4_sleep_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (state == ST_SLEEP) && !sdo);

  a_r3_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |-> sdo);

  a_r1_no_wake_in_err: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SLEEP) && mode_err && !cs_fall) |=> (state != ST_DATA));

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fall && !abort) |=> (state == ST_CONV) && sdo);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == ST_CONV));

  a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_last |=> $stable({chan_sgl, chan_odd, chan_addr}));
endmodule

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
  localparam int RES_W = 24;
  localparam int ADDR_W = 3;
  localparam int CONV = 200;
  localparam int H = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0, rsign = 0;
  logic [RES_W-1:0] rin = '0;
  logic sdo, sdo_en, mode_err, chan_sgl, chan_odd;
  logic [ADDR_W-1:0] chan_addr;

  int checks = 0, errors = 0;
  logic e_sgl = 0, e_odd = 0;
  logic [ADDR_W-1:0] e_addr = '0;

  adc_serial_port #(.RES_W(RES_W), .ADDR_W(ADDR_W), .CONV_CYCLES(CONV)) u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .result_sign(rsign), .result_in(rin), .sdo(sdo), .sdo_en(sdo_en),
    .mode_err(mode_err), .chan_sgl(chan_sgl), .chan_odd(chan_odd), .chan_addr(chan_addr));

  always #5 clk = ~clk;

  function automatic logic [31:0] frame_of(input logic s, input logic [RES_W-1:0] r);
    return {2'b00, s, r, {(32-3-RES_W){1'b0}}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_chan(input string req);
    check(req, {27'd0, chan_sgl, chan_odd, chan_addr}, {27'd0, e_sgl, e_odd, e_addr});
  endtask

  task automatic load_and_wait(input logic s, input logic [RES_W-1:0] r);
    rsign = s;
    rin = r;
    clks(CONV + 20);
  endtask

  task automatic xfer(input logic [5:0] w, input int nrise, input logic [31:0] fr);
    cs_n = 0;
    clks(H);
    check("R4 sleep flag", {31'd0, sdo}, 32'd0);
    for (int i = 0; i < nrise; i++) begin
      check(i == 0 ? "R5 first bit" : "R6 frame bit", {31'd0, sdo}, {31'd0, fr[31-i]});
      sdi = (i < 6) ? w[5-i] : 1'($urandom);
      clks(1);
      sck = 1;
      clks(H);
      if (i == nrise - 1 && nrise < 32) begin
        cs_n = 1;
        clks(H);
        sck = 0;
        clks(H);
      end else begin
        sck = 0;
        clks(H);
      end
    end
    if (nrise == 32) begin
      check("R7 busy after frame", {31'd0, sdo}, 32'd1);
      cs_n = 1;
      clks(H);
      check("R2 hi-z", {31'd0, sdo_en}, 32'd0);
    end else begin
      cs_n = 0;
      clks(H);
      check("R8 busy after abort", {31'd0, sdo}, 32'd1);
      cs_n = 1;
      clks(H);
    end
    if (nrise >= 6 && w[5]) begin
      e_sgl = w[4];
      e_odd = w[3];
      e_addr = w[2:0];
    end
    check_chan(nrise >= 6 ? "R10 channel word" : "R9 partial word dropped");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    logic [RES_W-1:0] r;
    void'($urandom(32'h5eed));
    clks(3);
    check("R11 mode_err reset", {31'd0, mode_err}, 32'd0);
    check_chan("R11 channel reset");
    check("R2 hi-z at reset", {31'd0, sdo_en}, 32'd0);
    rst_n = 1;
    clks(4);
    cs_n = 0;
    clks(H);
    check("R3 busy read", {31'd0, sdo}, 32'd1);
    check("R2 enabled", {31'd0, sdo_en}, 32'd1);
    cs_n = 1;
    load_and_wait(1'b1, 24'hA5C3F1);
    xfer(6'b111010, 32, frame_of(1'b1, 24'hA5C3F1));

    load_and_wait(1'b0, 24'h123456);
    xfer(6'b010101, 32, frame_of(1'b0, 24'h123456));

    load_and_wait(1'b1, 24'hFFFFFF);
    xfer(6'b100111, 5, frame_of(1'b1, 24'hFFFFFF));

    // R4: conversion ends into sleep while chip-select stays low
    cs_n = 0;
    clks(H);
    check("R4 busy with cs low", {31'd0, sdo}, 32'd1);
    load_and_wait(1'b0, 24'h00F00F);
    check("R4 sleep with cs low", {31'd0, sdo}, 32'd0);
    cs_n = 1;
    clks(H);

    // R1: chip-select fall with the clock high
    sck = 1;
    clks(H);
    cs_n = 0;
    clks(H);
    check("R1 mode flag set", {31'd0, mode_err}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      sck = 0; clks(H);
      sck = 1; clks(H);
    end
    check("R1 still asleep", {31'd0, sdo}, 32'd0);
    check_chan("R1 channel untouched");
    cs_n = 1;
    clks(H);
    sck = 0;
    clks(H);
    xfer(6'b101100, 32, frame_of(1'b0, 24'h00F00F));
    check("R1 mode flag cleared", {31'd0, mode_err}, 32'd0);

    for (int it = 0; it < 24; it++) begin
      s = 1'($urandom);
      r = RES_W'($urandom);
      load_and_wait(s, r);
      xfer(6'($urandom), ($urandom % 2) ? 32 : 1 + int'($urandom % 31), frame_of(s, r));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule